// File: doc/BRIEF.md
# Operand Address Generator for a 16/32-bit CISC Core

This block turns the 6-bit operand specifier of an instruction (a 3-bit mode and a 3-bit register number) plus an operand size into a final operand address. It covers twelve addressing forms. These are register direct, register indirect, indirect with auto-increment or auto-decrement, indirect with displacement and indirect with index. Mode 7 adds five more forms, picked by the register field: absolute short, absolute long, PC plus displacement, PC plus index, and immediate. It pulls extension words from an instruction-stream port and reads a register file through one combinational read port. It can also carry out the single operand read or write through a memory port that uses a request/acknowledge handshake.

The decoder starts a request with `start_i`. The block stays busy until `commit_i`. When the instruction commits, the pointer of an auto-increment or auto-decrement operand is handed back to the register file. An instruction that is abandoned before commit therefore leaves the address register untouched. Instruction decode, the arithmetic unit and the condition flags sit outside the block.

Top module: `oag_top`

## Requirements
- R1: For mode 0 (data register direct) and mode 1 (address register direct), a read returns the selected register in `result_o` and `ea_addr_o`, and issues no memory cycle. `rf_sel_o` bit 3 is 0 for a data register and 1 for an address register, and bits 2:0 give the number.
- R2: Mode 2 uses the address register value as the operand address, and a read returns the memory data at that address.
- R3: Mode 5 fetches one extension word, sign-extends it and adds it to the address register.
- R4: In the indexed modes (mode 6, and mode 7 with register 3), bit 15 of the extension word selects an address register (1) or a data register (0) as the index. Bits 14:12 give its number.
- R5: In the indexed modes, bit 11 of the extension word set uses the whole 32-bit index. Clear uses the sign-extended low 16 bits. Bits 7:0 are a signed displacement added to base plus index.
- R6: Mode 3 accesses at the pointer and yields pointer plus step. Mode 4 accesses at pointer minus step. The step is 4 for long size (code 2) and 2 for byte (code 0) and word (code 1).
- R7: `wb_en_o` pulses for exactly one cycle, in the cycle after `commit_i` is accepted, and only for modes 3 and 4. It carries the register number and the updated pointer. It never pulses before commit.
- R8: Absolute short (mode 7, register 0) sign-extends one extension word. Absolute long (mode 7, register 1) joins two words, the first word as the high half.
- R9: PC-relative modes (mode 7, registers 2 and 3) take `pc_i` as sampled in the cycle the request is accepted, before any extension word is fetched.
- R10: Immediate (mode 7, register 4) returns the extension data in `result_o`. Byte uses the low 8 bits of one word, word uses one word, and long uses two words (first word high). No memory cycle is issued.
- R11: A write (`op_i` = 2) in modes 0 and 1 returns `wdata_i` in `result_o` with no memory cycle. A write to an immediate issues no memory cycle. A write in a memory mode issues one cycle with `mem_we_o` high and `wdata_i` as data.
- R12: `done_o` is a one-cycle pulse once address and access are final. While busy, `start_i` is ignored until `commit_i` returns the block to idle.
- R13: A memory or extension request stays high, with a stable address, until it is acknowledged. `op_i` = 0 computes the address only, and `op_i` = 1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Accept a new operand request when idle |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register field (sub-mode for mode 7) |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| op_i | input | 2 | 0 address only, 1 read, 2 write |
| wdata_i | input | 32 | Data for a write |
| commit_i | input | 1 | Instruction commits; releases the block |
| busy_o | output | 1 | Request in progress or awaiting commit |
| done_o | output | 1 | One-cycle pulse: address and access final |
| ea_addr_o | output | 32 | Effective address |
| result_o | output | 32 | Operand read, immediate value, or direct write value |
| rf_sel_o | output | 4 | Register file read select |
| rf_val_i | input | 32 | Register file read data |
| pc_i | input | 32 | Program counter before extension fetch |
| ext_req_o | output | 1 | Extension word request |
| ext_ack_i | input | 1 | Extension word valid |
| ext_word_i | input | 16 | Extension word |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_size_o | output | 2 | Memory access size |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data |
| wb_en_o | output | 1 | Address register write-back strobe |
| wb_reg_o | output | 3 | Address register number for write-back |
| wb_val_o | output | 32 | Updated pointer |

## Verification
The hardest situation to reach is the indexed form, where the index comes from a second register file read. That read happens after the extension word has arrived, so the select comes from inside the block rather than from the ports. The stimulus sets data and address registers to values whose low halves sign-extend to something other than their full value. It then issues extension words that differ only in bit 15, bit 11 and the displacement sign, so a wrong select, width or extension gives a different address. The deferred pointer update is checked by sampling the write-back strobe at the done pulse and again after commit, and a start pulse is sent while the block waits for commit.

// File: rtl/oag_pkg.sv
package oag_pkg;
    localparam int EXT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT1,
        ST_EXT2,
        ST_INDEX,
        ST_MEM,
        ST_HOLD
    } oag_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam logic [1:0] OP_ADDR  = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    // internal mode numbers after mode 7 sub-decode
    localparam logic [3:0] IM_DREG  = 4'd0;
    localparam logic [3:0] IM_AREG  = 4'd1;
    localparam logic [3:0] IM_IND   = 4'd2;
    localparam logic [3:0] IM_POST  = 4'd3;
    localparam logic [3:0] IM_PRE   = 4'd4;
    localparam logic [3:0] IM_DISP  = 4'd5;
    localparam logic [3:0] IM_IDX   = 4'd6;
    localparam logic [3:0] IM_ABSW  = 4'd7;
    localparam logic [3:0] IM_ABSL  = 4'd8;
    localparam logic [3:0] IM_PCD   = 4'd9;
    localparam logic [3:0] IM_PCX   = 4'd10;
    localparam logic [3:0] IM_IMM   = 4'd11;
endpackage

// File: rtl/oag_step_unit.sv
module oag_step_unit #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] inc_o,
    output logic [ADDR_W-1:0] dec_o
);
    import oag_pkg::*;
    logic [ADDR_W-1:0] step;

    always_comb begin
        step  = (size_i == SZ_LONG) ? ADDR_W'(4) : ADDR_W'(2);
        inc_o = ptr_i + step;
        dec_o = ptr_i - step;
    end
endmodule

// File: rtl/oag_index_unit.sv
module oag_index_unit #(
    parameter int ADDR_W = 32
) (
    input  logic [oag_pkg::EXT_W-1:0] ext_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [ADDR_W-1:0]         idx_reg_i,
    output logic [3:0]                idx_sel_o,
    output logic [ADDR_W-1:0]         addr_o
);
    logic [ADDR_W-1:0] idx_val;
    logic [ADDR_W-1:0] disp;

    always_comb begin
        idx_sel_o = ext_i[15:12];
        if (ext_i[11]) begin
            idx_val = idx_reg_i;
        end else begin
            idx_val = {{(ADDR_W-16){idx_reg_i[15]}}, idx_reg_i[15:0]};
        end
        disp   = {{(ADDR_W-8){ext_i[7]}}, ext_i[7:0]};
        addr_o = base_i + idx_val + disp;
    end
endmodule

// File: rtl/oag_top.sv
module oag_top #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [2:0]        reg_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              commit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_addr_o,
    output logic [ADDR_W-1:0] result_o,
    output logic [3:0]        rf_sel_o,
    input  logic [ADDR_W-1:0] rf_val_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              ext_req_o,
    input  logic              ext_ack_i,
    input  logic [15:0]       ext_word_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              wb_en_o,
    output logic [2:0]        wb_reg_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    import oag_pkg::*;

    localparam int XW = EXT_W;

    typedef struct packed {
        oag_state_e        st;
        logic [3:0]        im;
        logic [1:0]        sz;
        logic [1:0]        op;
        logic [2:0]        rg;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] pc;
        logic [XW-1:0]     ext1;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] result;
        logic [ADDR_W-1:0] wdata;
        logic              done;
        logic              wb_en;
        logic [2:0]        wb_reg;
        logic [ADDR_W-1:0] wb_val;
    } oag_regs_t;

    oag_regs_t state_d, state_q;

    logic [3:0]        im_start;
    logic              mem_op_i, mem_op_q;
    logic [ADDR_W-1:0] ptr_inc, ptr_dec;
    logic [ADDR_W-1:0] idx_base, idx_addr;
    logic [3:0]        idx_sel;
    logic [ADDR_W-1:0] ext_sx;

    oag_step_unit #(.ADDR_W(ADDR_W)) i_step (
        .size_i (size_i),
        .ptr_i  (rf_val_i),
        .inc_o  (ptr_inc),
        .dec_o  (ptr_dec)
    );

    assign idx_base = (state_q.im == IM_PCX) ? state_q.pc : state_q.base;

    oag_index_unit #(.ADDR_W(ADDR_W)) i_index (
        .ext_i     (state_q.ext1),
        .base_i    (idx_base),
        .idx_reg_i (rf_val_i),
        .idx_sel_o (idx_sel),
        .addr_o    (idx_addr)
    );

    always_comb begin
        im_start = (mode_i == 3'd7) ? (4'd7 + {1'b0, reg_i}) : {1'b0, mode_i};
        mem_op_i = (op_i == OP_READ) || (op_i == OP_WRITE);
        mem_op_q = (state_q.op == OP_READ) || (state_q.op == OP_WRITE);
        ext_sx   = {{(ADDR_W-16){ext_word_i[15]}}, ext_word_i};
    end

    always_comb begin
        state_d       = state_q;
        state_d.done  = 1'b0;
        state_d.wb_en = 1'b0;
        rf_sel_o      = 4'd0;

        case (state_q.st)
            ST_IDLE: begin
                rf_sel_o = {(mode_i != 3'd0), reg_i};
                if (start_i) begin
                    state_d.im     = im_start;
                    state_d.sz     = size_i;
                    state_d.op     = op_i;
                    state_d.rg     = reg_i;
                    state_d.base   = rf_val_i;
                    state_d.pc     = pc_i;
                    state_d.wdata  = wdata_i;
                    state_d.result = '0;
                    state_d.ptr    = rf_val_i;
                    state_d.addr   = '0;
                    case (im_start)
                        IM_DREG, IM_AREG: begin
                            state_d.addr   = rf_val_i;
                            state_d.result = (op_i == OP_WRITE) ? wdata_i : rf_val_i;
                            state_d.st     = ST_HOLD;
                            state_d.done   = 1'b1;
                        end
                        IM_IND, IM_POST, IM_PRE: begin
                            state_d.addr = (im_start == IM_PRE) ? ptr_dec : rf_val_i;
                            state_d.ptr  = (im_start == IM_PRE) ? ptr_dec : ptr_inc;
                            state_d.st   = mem_op_i ? ST_MEM : ST_HOLD;
                            state_d.done = !mem_op_i;
                        end
                        IM_DISP, IM_IDX, IM_ABSW, IM_ABSL, IM_PCD, IM_PCX, IM_IMM: begin
                            state_d.st = ST_EXT1;
                        end
                        default: begin
                            state_d.st   = ST_HOLD;
                            state_d.done = 1'b1;
                        end
                    endcase
                end
            end

            ST_EXT1: begin
                if (ext_ack_i) begin
                    state_d.ext1 = ext_word_i;
                    case (state_q.im)
                        IM_DISP: begin
                            state_d.addr = state_q.base + ext_sx;
                            state_d.st   = mem_op_q ? ST_MEM : ST_HOLD;
                            state_d.done = !mem_op_q;
                        end
                        IM_ABSW: begin
                            state_d.addr = ext_sx;
                            state_d.st   = mem_op_q ? ST_MEM : ST_HOLD;
                            state_d.done = !mem_op_q;
                        end
                        IM_PCD: begin
                            state_d.addr = state_q.pc + ext_sx;
                            state_d.st   = mem_op_q ? ST_MEM : ST_HOLD;
                            state_d.done = !mem_op_q;
                        end
                        IM_IDX, IM_PCX: begin
                            state_d.st = ST_INDEX;
                        end
                        IM_ABSL: begin
                            state_d.st = ST_EXT2;
                        end
                        default: begin
                            if (state_q.sz == SZ_LONG) begin
                                state_d.st = ST_EXT2;
                            end else begin
                                state_d.result = (state_q.sz == SZ_BYTE)
                                    ? ADDR_W'(ext_word_i[7:0]) : ADDR_W'(ext_word_i);
                                state_d.addr   = state_d.result;
                                state_d.st     = ST_HOLD;
                                state_d.done   = 1'b1;
                            end
                        end
                    endcase
                end
            end

            ST_EXT2: begin
                if (ext_ack_i) begin
                    if (state_q.im == IM_ABSL) begin
                        state_d.addr = ADDR_W'({state_q.ext1, ext_word_i});
                        state_d.st   = mem_op_q ? ST_MEM : ST_HOLD;
                        state_d.done = !mem_op_q;
                    end else begin
                        state_d.result = ADDR_W'({state_q.ext1, ext_word_i});
                        state_d.addr   = state_d.result;
                        state_d.st     = ST_HOLD;
                        state_d.done   = 1'b1;
                    end
                end
            end

            ST_INDEX: begin
                rf_sel_o     = idx_sel;
                state_d.addr = idx_addr;
                state_d.st   = mem_op_q ? ST_MEM : ST_HOLD;
                state_d.done = !mem_op_q;
            end

            ST_MEM: begin
                if (mem_ack_i) begin
                    if (state_q.op == OP_READ) begin
                        state_d.result = mem_rdata_i;
                    end
                    state_d.st   = ST_HOLD;
                    state_d.done = 1'b1;
                end
            end

            ST_HOLD: begin
                if (commit_i) begin
                    state_d.st = ST_IDLE;
                    if (state_q.im == IM_POST || state_q.im == IM_PRE) begin
                        state_d.wb_en  = 1'b1;
                        state_d.wb_reg = state_q.rg;
                        state_d.wb_val = state_q.ptr;
                    end
                end
            end

            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o      = (state_q.st != ST_IDLE);
    assign done_o      = state_q.done;
    assign ea_addr_o   = state_q.addr;
    assign result_o    = state_q.result;
    assign ext_req_o   = (state_q.st == ST_EXT1) || (state_q.st == ST_EXT2);
    assign mem_req_o   = (state_q.st == ST_MEM);
    assign mem_we_o    = (state_q.op == OP_WRITE);
    assign mem_size_o  = state_q.sz;
    assign mem_addr_o  = state_q.addr;
    assign mem_wdata_o = state_q.wdata;
    assign wb_en_o     = state_q.wb_en;
    assign wb_reg_o    = state_q.wb_reg;
    assign wb_val_o    = state_q.wb_val;

    // R12: done is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12: once busy, the block stays busy until a commit arrives
    assert_busy_until_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !commit_i) |=> busy_o);

    // R7: write-back only directly after a commit
    assert_wb_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> $past(commit_i && busy_o));

    // R13: memory request held with a stable address until acknowledged
    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R13: extension request held until acknowledged
    assert_ext_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && !ext_ack_i) |=> ext_req_o);

    // R12: no bus activity outside a request
    assert_req_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o || ext_req_o) |-> busy_o);
endmodule

// File: tb/test_oag_top.sv
module test_oag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  rg = '0;
    logic [1:0]  size = '0;
    logic [1:0]  op = '0;
    logic [31:0] wdata = '0;
    logic        commit = 1'b0;
    logic        busy, done;
    logic [31:0] ea_addr, result;
    logic [3:0]  rf_sel;
    logic [31:0] rf_val;
    logic [31:0] pc = '0;
    logic        ext_req;
    logic        ext_ack = 1'b0;
    logic [15:0] ext_word = '0;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [2:0]  wb_reg;
    logic [31:0] wb_val;

    logic [31:0] rf [16];
    logic [15:0] ext_q [4];
    int          ext_cnt = 0;
    int          ext_base = 0;
    int          mem_cnt = 0;
    logic        last_we = 1'b0;
    logic [31:0] last_waddr = '0, last_wdata = '0;
    int          checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    assign rf_val = rf[rf_sel];

    oag_top i_oag_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .reg_i(rg),
        .size_i(size), .op_i(op), .wdata_i(wdata), .commit_i(commit),
        .busy_o(busy), .done_o(done), .ea_addr_o(ea_addr), .result_o(result),
        .rf_sel_o(rf_sel), .rf_val_i(rf_val), .pc_i(pc),
        .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_word_i(ext_word),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .wb_en_o(wb_en), .wb_reg_o(wb_reg), .wb_val_o(wb_val)
    );

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        if (ext_req && !ext_ack) begin
            ext_ack  <= 1'b1;
            ext_word <= ext_q[(ext_cnt - ext_base) & 3];
            ext_cnt  <= ext_cnt + 1;
        end else begin
            ext_ack <= 1'b0;
        end
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_f(mem_addr);
            mem_cnt   <= mem_cnt + 1;
            last_we   <= mem_we;
            if (mem_we) begin
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                         input logic [1:0] o, input logic [31:0] wd);
        int n;
        ext_base = ext_cnt;
        @(negedge clk);
        mode = m; rg = r; size = s; op = o; wdata = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R12 done seen", 32'(done), 32'd1);
    endtask

    task automatic do_commit(input string tag, input logic exp_wb, input logic [2:0] exp_reg,
                             input logic [31:0] exp_val);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk({tag, " wb_en"}, 32'(wb_en), 32'(exp_wb));
        if (exp_wb) begin
            chk({tag, " wb_reg"}, 32'(wb_reg), 32'(exp_reg));
            chk({tag, " wb_val"}, wb_val, exp_val);
        end
        chk({tag, " idle after commit"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk({tag, " wb single pulse"}, 32'(wb_en), 32'd0);
    endtask

    task automatic t_direct;
        int m0;
        m0 = mem_cnt;
        rf[3] = 32'h1122_3344;
        issue(3'd0, 3'd3, 2'd2, 2'd1, 32'h0);
        chk("R1 dreg result", result, 32'h1122_3344);
        do_commit("R1 dreg", 1'b0, 3'd0, 32'h0);
        rf[8+5] = 32'hCAFE_0005;
        issue(3'd1, 3'd5, 2'd2, 2'd1, 32'h0);
        chk("R1 areg result", result, 32'hCAFE_0005);
        do_commit("R1 areg", 1'b0, 3'd0, 32'h0);
        issue(3'd1, 3'd5, 2'd2, 2'd2, 32'h7777_8888);
        chk("R11 direct write value", result, 32'h7777_8888);
        do_commit("R11 direct", 1'b0, 3'd0, 32'h0);
        chk("R1 R11 no memory cycle", 32'(mem_cnt - m0), 32'd0);
    endtask

    task automatic t_indirect;
        rf[8+2] = 32'h0000_1000;
        issue(3'd2, 3'd2, 2'd1, 2'd1, 32'h0);
        chk("R2 address", ea_addr, 32'h0000_1000);
        chk("R2 read data", result, mem_f(32'h0000_1000));
        do_commit("R2 no wb", 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_postinc;
        rf[8+1] = 32'h0000_2000;
        issue(3'd3, 3'd1, 2'd2, 2'd1, 32'h0);
        chk("R6 post long addr", ea_addr, 32'h0000_2000);
        chk("R7 no wb before commit", 32'(wb_en), 32'd0);
        do_commit("R7 post long", 1'b1, 3'd1, 32'h0000_2004);
        issue(3'd3, 3'd1, 2'd0, 2'd0, 32'h0);
        do_commit("R6 post byte step 2", 1'b1, 3'd1, 32'h0000_2002);
    endtask

    task automatic t_predec;
        int m0;
        m0 = mem_cnt;
        rf[8+4] = 32'h0000_3000;
        issue(3'd4, 3'd4, 2'd1, 2'd2, 32'hABCD_1234);
        chk("R6 pre word addr", ea_addr, 32'h0000_2FFE);
        chk("R11 one write cycle", 32'(mem_cnt - m0), 32'd1);
        chk("R11 write flag", 32'(last_we), 32'd1);
        chk("R11 write addr", last_waddr, 32'h0000_2FFE);
        chk("R11 write data", last_wdata, 32'hABCD_1234);
        chk("R7 no wb before commit", 32'(wb_en), 32'd0);
        do_commit("R7 pre word", 1'b1, 3'd4, 32'h0000_2FFE);
        issue(3'd4, 3'd4, 2'd2, 2'd0, 32'h0);
        chk("R6 pre long addr", ea_addr, 32'h0000_2FFC);
        do_commit("R6 pre long", 1'b1, 3'd4, 32'h0000_2FFC);
    endtask

    task automatic t_disp;
        rf[8+6] = 32'h0000_4000;
        ext_q[0] = 16'hFFF0;
        issue(3'd5, 3'd6, 2'd1, 2'd1, 32'h0);
        chk("R3 disp addr", ea_addr, 32'h0000_3FF0);
        chk("R3 disp read", result, mem_f(32'h0000_3FF0));
        do_commit("R3", 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_index;
        rf[8+0] = 32'h0000_5000;
        rf[2]   = 32'h0001_FFFE;
        rf[8+3] = 32'h0001_0000;
        ext_q[0] = 16'h2010;  // D2, low half, +16
        issue(3'd6, 3'd0, 2'd1, 2'd0, 32'h0);
        chk("R4 R5 data reg word index", ea_addr, 32'h0000_500E);
        do_commit("R5 a", 1'b0, 3'd0, 32'h0);
        ext_q[0] = 16'hB8F0;  // A3, full, -16
        issue(3'd6, 3'd0, 2'd1, 2'd0, 32'h0);
        chk("R4 R5 addr reg long index", ea_addr, 32'h0001_4FF0);
        do_commit("R4 b", 1'b0, 3'd0, 32'h0);
        ext_q[0] = 16'hA000;  // A2 word (low half of 0x1000), disp 0
        rf[8+2] = 32'h0003_1000;
        issue(3'd6, 3'd0, 2'd1, 2'd0, 32'h0);
        chk("R5 word index drops upper half", ea_addr, 32'h0000_6000);
        do_commit("R5 c", 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_abs;
        ext_q[0] = 16'h8000;
        issue(3'd7, 3'd0, 2'd1, 2'd0, 32'h0);
        chk("R8 abs short", ea_addr, 32'hFFFF_8000);
        do_commit("R8 a", 1'b0, 3'd0, 32'h0);
        ext_q[0] = 16'h0012; ext_q[1] = 16'h3456;
        issue(3'd7, 3'd1, 2'd2, 2'd1, 32'h0);
        chk("R8 abs long", ea_addr, 32'h0012_3456);
        chk("R8 abs long read", result, mem_f(32'h0012_3456));
        chk("R13 read size on bus", 32'(mem_size), 32'd2);
        do_commit("R8 b", 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_pcrel;
        pc = 32'h0000_1000;
        ext_q[0] = 16'h0020;
        issue(3'd7, 3'd2, 2'd1, 2'd0, 32'h0);
        pc = 32'h0;
        chk("R9 pc disp", ea_addr, 32'h0000_1020);
        do_commit("R9 a", 1'b0, 3'd0, 32'h0);
        pc = 32'h0000_2000;
        rf[0] = 32'h0000_0010;
        ext_q[0] = 16'h0004;
        issue(3'd7, 3'd3, 2'd1, 2'd0, 32'h0);
        pc = 32'h0;
        chk("R9 R4 pc index", ea_addr, 32'h0000_2014);
        do_commit("R9 b", 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_imm;
        int m0, e0;
        m0 = mem_cnt;
        ext_q[0] = 16'h12AB;
        issue(3'd7, 3'd4, 2'd0, 2'd1, 32'h0);
        chk("R10 imm byte", result, 32'h0000_00AB);
        do_commit("R10 a", 1'b0, 3'd0, 32'h0);
        issue(3'd7, 3'd4, 2'd1, 2'd1, 32'h0);
        chk("R10 imm word", result, 32'h0000_12AB);
        do_commit("R10 b", 1'b0, 3'd0, 32'h0);
        e0 = ext_cnt;
        ext_q[0] = 16'hDEAD; ext_q[1] = 16'hBEEF;
        issue(3'd7, 3'd4, 2'd2, 2'd1, 32'h0);
        chk("R10 imm long", result, 32'hDEAD_BEEF);
        chk("R10 two ext words", 32'(ext_cnt - e0), 32'd2);
        do_commit("R10 c", 1'b0, 3'd0, 32'h0);
        issue(3'd7, 3'd4, 2'd1, 2'd2, 32'h5555_5555);
        do_commit("R11 imm write", 1'b0, 3'd0, 32'h0);
        chk("R10 R11 no memory cycle", 32'(mem_cnt - m0), 32'd0);
    endtask

    task automatic t_busy;
        rf[8+2] = 32'h0000_1000;
        issue(3'd2, 3'd2, 2'd1, 2'd0, 32'h0);
        @(negedge clk);
        mode = 3'd7; rg = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 start ignored addr", ea_addr, 32'h0000_1000);
        chk("R12 start ignored done", 32'(done), 32'd0);
        chk("R12 still busy", 32'(busy), 32'd1);
        chk("R12 no ext request", 32'(ext_req), 32'd0);
        do_commit("R12", 1'b0, 3'd0, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        for (int i = 0; i < 4; i++) ext_q[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", 32'(busy), 32'd0);
        chk("R12 reset done", 32'(done), 32'd0);
        chk("R13 reset mem req", 32'(mem_req), 32'd0);
        chk("R7 reset wb", 32'(wb_en), 32'd0);
        t_direct();
        t_indirect();
        t_postinc();
        t_predec();
        t_disp();
        t_index();
        t_abs();
        t_pcrel();
        t_imm();
        t_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule